// File: doc/BRIEF.md
# FPGA Configuration Loader for an 8-bit Host Bus

This block connects an 8-bit host I/O bus to the configuration port of an SRAM-based FPGA. The host writes command bytes into a 256-byte window. Only the two top address bits and the chip select decode that window into four regions: data, global reset, control, and an unused region. From those writes the block drives the FPGA mode pins and the global reset. It also pulls the configuration-start line low, and it presents each configuration byte with exactly one configuration-clock pulse.

The configuration-start line is open drain and shared. The block can only pull it low. Once loading is under way, the FPGA holds the line low itself and lets it go when loading ends. The host polls the control region and reads the synchronized level of the line on data bit 0, where a 1 means loading is complete.

A typical session has four steps. The host writes 0x07 to the control region, which pulls the line low and selects sequential-load mode 6. It then writes the bitstream bytes one at a time to the data region and polls until bit 0 reads 1. Finally it writes 0x04 to the control region to return to normal mode 4.

Top module: `cfg_loader`

## Requirements
- R1: A host access is decoded only while `sel_i` is high. The region is given by `addr_i[7:6]`: 01 is data, 10 is reset, 11 is control and 00 is unused. The low six address bits are ignored. A write to region 00, or a write made with `sel_i` low, changes no output.
- R2: A write takes effect in the first clock cycle after `wr_i` (qualified by `sel_i`) deasserts. A strobe held for several cycles counts as one write and uses the address and data of its last cycle.
- R3: A data write loads `cfg_data_o` with the byte and raises `cclk_o` for exactly one cycle, in the cycle after the strobe deasserts. `cfg_data_o` then stays unchanged until the next data write.
- R4: A write of any value to the reset region holds `fpga_rst_o` high for exactly RST_LEN cycles, starting in the cycle after the strobe deasserts.
- R5: A control write sets `con_pull_o` (1 means the configuration-start line is pulled low) from data bit 0. It sets `mode_o` to {d[2], d[1], d[3]}, so that 0x07 gives mode 6 with the pull active and 0x04 gives mode 4 with the pull released.
- R6: The first data write after the pull was set releases `con_pull_o`, so that the FPGA alone holds the line while it loads. The mode is left unchanged.
- R7: A read of the control region returns the level of `con_i`, synchronized through SYNC_STAGES flip-flops, on bit 0, with all other bits 0.
- R8: `rdata_o` is 0 whenever `rd_i` or `sel_i` is low, and for reads of the data, reset or unused regions.
- R9: After reset, `cclk_o`, `fpga_rst_o`, `con_pull_o` and `cfg_data_o` are 0 and `mode_o` is 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Chip select for the 256-byte window |
| addr_i | input | 8 | Host address; bits 7:6 select the region |
| wr_i | input | 1 | Host write strobe, active high |
| rd_i | input | 1 | Host read strobe, active high |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Host read data |
| con_i | input | 1 | Sensed level of the open-drain configuration-start line |
| con_pull_o | output | 1 | 1 pulls the configuration-start line low; the line is never driven high |
| mode_o | output | 3 | FPGA configuration mode pins |
| fpga_rst_o | output | 1 | FPGA global reset |
| cclk_o | output | 1 | Configuration clock |
| cfg_data_o | output | 8 | Configuration data byte |

## Verification
The bench builds the block with RST_LEN=3 and SYNC_STAGES=3, both different from the defaults. This exercises the reset-pulse counter and the synchronizer chain at a length other than the defaults. The bench checks the exact pulse length by counting high cycles. It models the shared line as the wired-AND of the block's pull and an FPGA-side pull. That model allows a full download to be checked: start, release of the pull on the first byte, polling while the FPGA holds the line, and completion. Aliased addresses, the unused region, deselected writes and stretched strobes cover the decode corners.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

  typedef enum logic [1:0] {
    REG_NONE  = 2'b00,
    REG_DATA  = 2'b01,
    REG_RESET = 2'b10,
    REG_CTRL  = 2'b11
  } region_e;

  localparam logic [2:0] MODE_INIT = 3'b100;

  // control bits 3:1 rotated onto the mode pins: 0x07 -> 6, 0x04 -> 4
  function automatic logic [2:0] ctl_to_mode(input logic [3:1] b);
    return {b[2], b[1], b[3]};
  endfunction

endpackage

// File: rtl/cfg_host_port.sv
module cfg_host_port
  import cfg_loader_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_i,
  input  region_e       region_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          go_o,
  output region_e       region_o,
  output logic [DW-1:0] data_o
);

  logic          wr_act;
  logic          pend_q;
  region_e       region_q;
  logic [DW-1:0] data_q;

  assign wr_act = wr_i & sel_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= 1'b0;
      region_q <= REG_NONE;
      data_q   <= '0;
    end else if (wr_act) begin
      pend_q   <= 1'b1;
      region_q <= region_i;
      data_q   <= wdata_i;
    end else begin
      pend_q   <= 1'b0;
    end
  end

  // commit once the strobe has dropped
  assign go_o     = pend_q & ~wr_act;
  assign region_o = region_q;
  assign data_o   = data_q;

  // R2
  one_commit_per_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_o |=> !go_o);

endmodule

// File: rtl/cfg_cclk_gen.sv
module cfg_cclk_gen
  import cfg_loader_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  region_e       region_i,
  input  logic [DW-1:0] data_i,
  output logic          cclk_o,
  output logic [DW-1:0] cfg_data_o
);

  logic          fire;
  logic          cclk_q;
  logic [DW-1:0] byte_q;

  assign fire = go_i & (region_i == REG_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cclk_q <= 1'b0;
      byte_q <= '0;
    end else begin
      cclk_q <= fire;
      if (fire) byte_q <= data_i;
    end
  end

  assign cclk_o     = cclk_q;
  assign cfg_data_o = byte_q;

  // R3
  cclk_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cclk_o |=> !cclk_o);

  // R3
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cclk_o |=> $stable(cfg_data_o));

  // R3
  cclk_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cclk_o) |-> $past(go_i) && ($past(region_i) == REG_DATA));

endmodule

// File: rtl/cfg_ctrl.sv
module cfg_ctrl
  import cfg_loader_pkg::*;
#(
  parameter int RST_LEN = 16,
  localparam int CNT_W  = $clog2(RST_LEN + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       go_i,
  input  region_e    region_i,
  input  logic [3:0] ctl_i,
  output logic       con_pull_o,
  output logic [2:0] mode_o,
  output logic       fpga_rst_o
);

  logic             ctl_go, rst_go, data_go;
  logic             pull_q;
  logic [2:0]       mode_q;
  logic [CNT_W-1:0] rst_cnt_q;

  assign ctl_go  = go_i & (region_i == REG_CTRL);
  assign rst_go  = go_i & (region_i == REG_RESET);
  assign data_go = go_i & (region_i == REG_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pull_q <= 1'b0;
      mode_q <= MODE_INIT;
    end else if (ctl_go) begin
      pull_q <= ctl_i[0];
      mode_q <= ctl_to_mode(ctl_i[3:1]);
    end else if (data_go) begin
      pull_q <= 1'b0;  // FPGA holds the line from here on
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                rst_cnt_q <= '0;
    else if (rst_go)            rst_cnt_q <= CNT_W'(RST_LEN);
    else if (rst_cnt_q != '0)   rst_cnt_q <= rst_cnt_q - 1'b1;
  end

  assign con_pull_o = pull_q;
  assign mode_o     = mode_q;
  assign fpga_rst_o = (rst_cnt_q != '0);

  // R5
  pull_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_go && ctl_i[0]) |=> con_pull_o);

  // R6
  pull_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_go |=> !con_pull_o);

  // R4
  rst_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fpga_rst_o) |-> $past(rst_go));

  // R6
  mode_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_go |=> $stable(mode_o));

endmodule

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int   STAGES = 2,
  parameter logic INIT   = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q[0] <= INIT;
    else         q[0] <= d_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q[i] <= INIT;
      else         q[i] <= q[i-1];
    end
  end

  assign q_o = q[STAGES-1];

endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int AW          = 8,
  parameter int DW          = 8,
  parameter int RST_LEN     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_i,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          con_i,
  output logic          con_pull_o,
  output logic [2:0]    mode_o,
  output logic          fpga_rst_o,
  output logic          cclk_o,
  output logic [DW-1:0] cfg_data_o
);

  region_e       region_in, cmd_region;
  logic          cmd_go;
  logic [DW-1:0] cmd_data;
  logic          con_s;
  logic          unused_addr;

  assign region_in   = region_e'(addr_i[AW-1 -: 2]);
  assign unused_addr = ^addr_i[AW-3:0];

  cfg_host_port #(.DW(DW)) u_port (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_i    (sel_i),
    .region_i (region_in),
    .wr_i     (wr_i),
    .wdata_i  (wdata_i),
    .go_o     (cmd_go),
    .region_o (cmd_region),
    .data_o   (cmd_data)
  );

  cfg_cclk_gen #(.DW(DW)) u_cclk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .go_i       (cmd_go),
    .region_i   (cmd_region),
    .data_i     (cmd_data),
    .cclk_o     (cclk_o),
    .cfg_data_o (cfg_data_o)
  );

  cfg_ctrl #(.RST_LEN(RST_LEN)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .go_i       (cmd_go),
    .region_i   (cmd_region),
    .ctl_i      (cmd_data[3:0]),
    .con_pull_o (con_pull_o),
    .mode_o     (mode_o),
    .fpga_rst_o (fpga_rst_o)
  );

  cfg_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (con_i),
    .q_o    (con_s)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_i && sel_i && region_in == REG_CTRL) rdata_o[0] = con_s;
  end

  // R8
  rd_idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i && sel_i) |-> rdata_o == '0);

  // R7
  rd_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DW-1:1] == '0);

endmodule

// File: tb/sim_cfg_loader.sv
module sim_cfg_loader;

  localparam int  DW       = 8;
  localparam int  RST_LEN  = 3;
  localparam int  SYNC_N   = 3;
  localparam time CLK_T    = 4ns;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          sel = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [7:0]    addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          con_line, con_pull, fpga_hold = 1'b0;
  logic [2:0]    mode;
  logic          frst, cclk;
  logic [DW-1:0] cdata;

  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_T/2) clk = ~clk;

  // wired-AND of the open-drain line
  assign con_line = ~(con_pull | fpga_hold);

  cfg_loader #(.AW(8), .DW(DW), .RST_LEN(RST_LEN), .SYNC_STAGES(SYNC_N)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sel_i(sel), .addr_i(addr), .wr_i(wr),
    .rd_i(rd), .wdata_i(wdata), .rdata_o(rdata), .con_i(con_line),
    .con_pull_o(con_pull), .mode_o(mode), .fpga_rst_o(frst),
    .cclk_o(cclk), .cfg_data_o(cdata)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  // write with strobe held n cycles; returns at the negedge where wr drops
  task automatic bus_wr(input logic [7:0] a, input logic [7:0] d,
                        input logic s = 1'b1, input int n = 1);
    @(negedge clk);
    sel = s; addr = a; wdata = d; wr = 1'b1;
    for (int i = 1; i < n; i++) begin
      @(negedge clk);
      wdata = d + 8'(i);
    end
    @(negedge clk);
    wr = 1'b0; sel = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, input logic s, input string tag,
                        input int exp);
    @(negedge clk);
    sel = s; addr = a; rd = 1'b1;
    #1;
    chk_eq(tag, int'(rdata), exp);
    @(negedge clk);
    rd = 1'b0; sel = 1'b0;
  endtask

  task automatic t_reset_state();
    chk_eq("R9 cclk", int'(cclk), 0);
    chk_eq("R9 fpga_rst", int'(frst), 0);
    chk_eq("R9 con_pull", int'(con_pull), 0);
    chk_eq("R9 mode", int'(mode), 4);
    chk_eq("R9 cfg_data", int'(cdata), 0);
    chk_eq("R8 idle rdata", int'(rdata), 0);
  endtask

  task automatic t_reset_pulse();
    int hi = 0;
    bus_wr(8'h80, 8'h5A);
    chk_eq("R4 rst not yet", int'(frst), 0);
    for (int i = 0; i < RST_LEN + 3; i++) begin
      @(negedge clk);
      if (frst) hi++;
      if (i == 0) chk_eq("R4 rst starts next cycle", int'(frst), 1);
    end
    chk_eq("R4 rst length", hi, RST_LEN);
  endtask

  task automatic t_data_byte(input logic [7:0] b);
    bus_wr(8'h40, b);
    chk_eq("R3 cclk low before commit", int'(cclk), 0);
    @(negedge clk);
    chk_eq("R3 cclk high", int'(cclk), 1);
    chk_eq("R3 data presented", int'(cdata), int'(b));
    @(negedge clk);
    chk_eq("R3 cclk one cycle", int'(cclk), 0);
    chk_eq("R3 data held", int'(cdata), int'(b));
  endtask

  task automatic t_download();
    bus_wr(8'hC0, 8'h07);
    @(negedge clk);
    chk_eq("R5 start pull", int'(con_pull), 1);
    chk_eq("R5 start mode", int'(mode), 6);
    fpga_hold = 1'b1;
    t_data_byte(8'hA5);
    chk_eq("R6 pull released", int'(con_pull), 0);
    chk_eq("R6 mode kept", int'(mode), 6);
    t_data_byte(8'h3C);
    t_data_byte(8'hFF);
    repeat (SYNC_N + 2) @(negedge clk);
    bus_rd(8'hC0, 1'b1, "R7 loading reads 0", 0);
    fpga_hold = 1'b0;
    repeat (SYNC_N + 2) @(negedge clk);
    bus_rd(8'hC0, 1'b1, "R7 done reads 1", 1);
    bus_rd(8'hC4, 1'b1, "R1 low bits ignored", 1);
    bus_wr(8'hC0, 8'h04);
    @(negedge clk);
    chk_eq("R5 normal mode", int'(mode), 4);
    chk_eq("R5 normal pull", int'(con_pull), 0);
  endtask

  task automatic t_no_effect();
    int pulses = 0, rsts = 0;
    bus_wr(8'h00, 8'h07);
    bus_wr(8'h40, 8'h11, 1'b0);
    bus_wr(8'hC0, 8'h07, 1'b0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (cclk) pulses++;
      if (frst) rsts++;
    end
    chk_eq("R1 no cclk", pulses, 0);
    chk_eq("R1 no reset", rsts, 0);
    chk_eq("R1 mode unchanged", int'(mode), 4);
    chk_eq("R1 pull unchanged", int'(con_pull), 0);
    chk_eq("R1 data unchanged", int'(cdata), 8'hFF);
  endtask

  task automatic t_long_strobe();
    int pulses = 0;
    // data 0x20, 0x21, 0x22 over three cycles; last one counts
    bus_wr(8'h7F, 8'h20, 1'b1, 3);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (cclk) pulses++;
    end
    chk_eq("R2 one pulse", pulses, 1);
    chk_eq("R2 last data", int'(cdata), 8'h22);
  endtask

  task automatic t_reads();
    bus_rd(8'h40, 1'b1, "R8 data region", 0);
    bus_rd(8'h80, 1'b1, "R8 reset region", 0);
    bus_rd(8'h00, 1'b1, "R8 unused region", 0);
    bus_rd(8'hC0, 1'b0, "R8 deselected", 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_reset_pulse();
    t_download();
    t_no_effect();
    t_long_strobe();
    t_reads();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule